// File: doc/BRIEF.md
# System Tick Down-Counter

This block is a periodic down-counter for an operating-system heartbeat. Software sets a reload value and then enables the counter. The counter steps down once per tick of the selected time base. The time base is either every core clock cycle or a single-cycle reference strobe that comes from outside the block. When the counter has passed through zero, the block does three things: it marks the expiry in a sticky flag, it can send a one-cycle request to an interrupt controller, and it loads the reload value again for the next period. If the reload value is zero, the counter switches itself off after that expiry.

Access is through a simple word-wide port with a two-bit word index and separate read and write strobes. Read data is combinational from the current state. The side effects of a read or write take place at the clock edge that ends the access cycle. The register at index 0 holds the control bits and the sticky flag. Index 1 is the reload value, index 2 is the live count, and index 3 is a fixed calibration constant.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, every register reads zero except the calibration word, and `irq_o` is low.
- R2: Writing index 0 changes only bit 0 (run), bit 1 (request enable) and bit 2 (time-base select). The flag at bit 16 and every other bit are unaffected by the written data.
- R3: Reading index 0 returns the control bits and the flag, then clears the flag at the end of the access. If an expiry happens in the same cycle, the flag stays set.
- R4: Setting the run bit from 0 loads the count from the reload register. Each tick then lowers the count by one, so one period lasts reload+1 ticks.
- R5: Each expiry sets the flag. When the request-enable bit is 1, `irq_o` goes high for exactly one cycle, starting the cycle after the expiry. When that bit is 0, `irq_o` stays low.
- R6: If the reload value is zero at expiry, the run bit clears and counting stops. Otherwise the count reloads and continues.
- R7: Any write to index 2 clears the flag, whatever the data. If the counter is running, the write also reloads the count from the reload register.
- R8: While the run bit is 0, index 2 reads zero and the count is not stepped.
- R9: Index 3 always reads 10000 decimal.
- R10: Time-base bit 1 steps on every core clock cycle. Time-base bit 0 steps only in cycles where `ref_tick_i` is high. Changing the time-base bit while running restarts the count from the reload value.
- R11: The reload register keeps the low CNT_W bits of the written data and reads back zero-extended. Writing it does not alter the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Single-cycle reference time-base strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers read side effects) |
| addr_i | input | 2 | Word index: 0 control, 1 reload, 2 count, 3 calibration |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the selected word |
| irq_o | output | 1 | One-cycle expiry request |

## Verification
On every cycle, the assertions check four things: the request lasts one cycle, a running counter steps down by exactly one, a stopped counter holds, and a zero reload turns the counter off at expiry. They also check that a count write clears the flag, that control writes land in the right bits, and that the calibration word is constant. Other behaviour can only be shown by the bench's scenarios. These are the true period length measured in request pulses, and that the sticky flag survives a read that coincides with an expiry. They also cover the difference between core-clock and strobe time bases, the restart on a time-base change, and the reads of zero while stopped.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_CALIB   = 2'd3
  } tick_reg_e;

  localparam int BIT_RUN  = 0;
  localparam int BIT_IRQE = 1;
  localparam int BIT_CORE = 2;
  localparam int BIT_FLAG = 16;

  localparam logic [31:0] CALIB_WORD = 32'd10000;

endpackage

// File: rtl/tick_src_sel.sv
module tick_src_sel (
  input  logic run_i,
  input  logic core_sel_i,
  input  logic ref_tick_i,
  output logic tick_o
);
  assign tick_o = run_i & (core_sel_i | ref_tick_i);
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] count_q, count_n;

  always_comb begin
    count_n = count_q;
    if (load_i)      count_n = load_val_i;
    else if (step_i) count_n = count_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_n;
  end

  assign count_o = count_q;
  assign zero_o  = (count_q == '0);
endmodule

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             tick_i,
  input  logic             zero_i,
  output logic             run_o,
  output logic             irqe_o,
  output logic             core_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             load_o,
  output logic             step_o,
  output logic             irq_o
);
  logic             run_q, run_n, irqe_q, irqe_n, core_q, core_n;
  logic             flag_q, flag_n, irq_q, irq_n;
  logic [CNT_W-1:0] reload_q, reload_n;

  logic wr_ctrl, wr_rel, wr_cur, rd_ctrl;
  logic new_run, new_core, restart, stop, cur_load, hold, expire, rel_zero;

  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
  assign wr_rel  = wr_en_i && (addr_i == REG_RELOAD);
  assign wr_cur  = wr_en_i && (addr_i == REG_CURRENT);
  assign rd_ctrl = rd_en_i && (addr_i == REG_CTRL);

  assign new_run  = wdata_i[BIT_RUN];
  assign new_core = wdata_i[BIT_CORE];

  // restart: start from stopped, or change time base while running
  assign restart  = wr_ctrl && new_run && (!run_q || (new_core != core_q));
  assign stop     = wr_ctrl && !new_run;
  assign cur_load = wr_cur && run_q;
  assign hold     = restart || stop || cur_load;
  assign rel_zero = (reload_q == '0);
  assign expire   = tick_i && zero_i && !hold;

  assign load_o = restart || cur_load || (expire && !rel_zero);
  assign step_o = tick_i && !zero_i && !hold;

  always_comb begin
    run_n    = run_q;
    irqe_n   = irqe_q;
    core_n   = core_q;
    reload_n = reload_q;
    flag_n   = flag_q;
    if (wr_ctrl) begin
      run_n  = new_run;
      irqe_n = wdata_i[BIT_IRQE];
      core_n = new_core;
    end
    if (expire && rel_zero) run_n = 1'b0;
    if (wr_rel) reload_n = wdata_i;
    if (rd_ctrl || wr_cur) flag_n = 1'b0;
    if (expire) flag_n = 1'b1;
    irq_n = expire && irqe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      irqe_q   <= 1'b0;
      core_q   <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      run_q    <= run_n;
      irqe_q   <= irqe_n;
      core_q   <= core_n;
      flag_q   <= flag_n;
      irq_q    <= irq_n;
      reload_q <= reload_n;
    end
  end

  assign run_o    = run_q;
  assign irqe_o   = irqe_q;
  assign core_o   = core_q;
  assign flag_o   = flag_q;
  assign reload_o = reload_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             run, irqe, core, flag, tick, load, step, zero;
  logic [CNT_W-1:0] reload, count;

  generate
    if (DATA_W > CNT_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:CNT_W];
    end
  endgenerate

  tick_src_sel u_src (
    .run_i      (run),
    .core_sel_i (core),
    .ref_tick_i (ref_tick_i),
    .tick_o     (tick)
  );

  tick_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i[CNT_W-1:0]),
    .tick_i   (tick),
    .zero_i   (zero),
    .run_o    (run),
    .irqe_o   (irqe),
    .core_o   (core),
    .flag_o   (flag),
    .reload_o (reload),
    .load_o   (load),
    .step_o   (step),
    .irq_o    (irq_o)
  );

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (reload),
    .step_i     (step),
    .count_o    (count),
    .zero_o     (zero)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[BIT_RUN]  = run;
        rdata_o[BIT_IRQE] = irqe;
        rdata_o[BIT_CORE] = core;
        rdata_o[BIT_FLAG] = flag;
      end
      REG_RELOAD:  rdata_o = DATA_W'(reload);
      REG_CURRENT: rdata_o = run ? DATA_W'(count) : '0;
      default:     rdata_o = DATA_W'(CALIB_WORD);
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [2:0]        wlow_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              run,
  input logic              irqe,
  input logic              core,
  input logic              flag,
  input logic              tick,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload
);
  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count != '0 && !wr_en_i) |=> (count == $past(count) - CNT_W'(1)));

  // R6
  auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count == '0 && reload == '0 && !wr_en_i) |=> !run);

  // R7
  cur_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd2) |=> !flag);

  // R8
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en_i) |=> $stable(count));

  // R2
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd0) |=> (irqe == $past(wlow_i[1]) && core == $past(wlow_i[2])));

  // R9
  calib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 2'd3) |-> (rdata_o == DATA_W'(10000)));
endmodule

bind sys_tick_timer tick_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wlow_i  (wdata_i[2:0]),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .run     (run),
  .irqe    (irqe),
  .core    (core),
  .flag    (flag),
  .tick    (tick),
  .count   (count),
  .reload  (reload)
);

// File: tb/test_sys_tick_timer.sv
module test_sys_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick_i, wr_en_i, rd_en_i;
  logic [1:0]  addr_i;
  logic [31:0] wdata_i, rdata_o;
  logic        irq_o;

  sys_tick_timer i_sys_tick_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  int   irq_cnt = 0, irq_run = 0, irq_max = 0;
  bit   done = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: samples one ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rst_n) begin
        if (irq_o) begin
          irq_cnt++;
          irq_run++;
          if (irq_run > irq_max) irq_max = irq_run;
        end else irq_run = 0;
        if (rd_en_i) begin
          if (exp_q.size() == 0) check(32'hx, 32'h0, "scoreboard underflow");
          else begin
            exp_t e;
            e = exp_q.pop_front();
            check(rdata_o, e.val, e.tag);
          end
        end
      end
    end
  end

  // driver tasks: called at a falling edge, return at the next one
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    exp_q.push_back(it);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ref_pulse();
    ref_tick_i = 1'b1;
    @(negedge clk);
    ref_tick_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ref_tick_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    addr_i = 2'd0; wdata_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check({31'd0, irq_o}, 32'd0, "R1 irq at reset");
    rd(2'd0, 32'h0, "R1 control reset");
    rd(2'd1, 32'h0, "R1 reload reset");
    rd(2'd2, 32'h0, "R1 count reset");
    rd(2'd3, 32'd10000, "R9 calibration");

    // R4/R5 core clock, reload 4, request enabled
    wr(2'd1, 32'd4);
    wr(2'd0, 32'h7);
    rd(2'd2, 32'd4, "R4 load on start");
    rd(2'd2, 32'd3, "R4 step by one");
    rd(2'd0, 32'h7, "R2 control bits");
    idle(16);
    rd(2'd0, 32'h1_0007, "R5 flag after expiry");
    wr(2'd0, 32'h0);
    idle(3);
    rd(2'd0, 32'h1_0000, "R3 flag kept when read meets expiry");
    rd(2'd0, 32'h0, "R3 flag cleared by read");
    rd(2'd2, 32'h0, "R8 stopped count reads zero");
    check(irq_cnt, 4, "R4 pulses over four periods of reload+1");
    check(irq_max, 1, "R5 one-cycle pulse");

    // R6 zero reload turns itself off
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h7);
    idle(2);
    rd(2'd0, 32'h1_0006, "R6 run cleared after zero-reload expiry");
    check(irq_cnt, 5, "R6 single expiry request");
    rd(2'd0, 32'h0000_0006, "R3 flag cleared");

    // R10 reference strobe time base, requests off
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h1);
    rd(2'd2, 32'd2, "R4 load from reload");
    idle(4);
    rd(2'd2, 32'd2, "R10 no step without strobe");
    ref_pulse();
    rd(2'd2, 32'd1, "R10 step on strobe");
    ref_pulse();
    ref_pulse();
    rd(2'd2, 32'd2, "R4 reload after expiry");
    rd(2'd0, 32'h1_0001, "R5 flag with requests off");
    rd(2'd0, 32'h1, "R3 flag cleared");
    check(irq_cnt, 5, "R5 no request when disabled");

    // R7 count write reloads and clears flag
    ref_pulse();
    ref_pulse();
    ref_pulse();
    ref_pulse();
    wr(2'd2, 32'h0000_dead);
    rd(2'd2, 32'd2, "R7 count write reloads");
    rd(2'd0, 32'h1, "R7 count write clears flag");

    // R10/R11 time base change restarts, reload write leaves count
    ref_pulse();
    wr(2'd1, 32'd9);
    rd(2'd2, 32'd1, "R11 reload write keeps count");
    wr(2'd0, 32'h5);
    rd(2'd2, 32'd9, "R10 restart on time base change");
    rd(2'd2, 32'd8, "R10 core clock steps every cycle");
    wr(2'd0, 32'h0);

    // R11/R2 field widths
    wr(2'd1, 32'hffff_ffff);
    rd(2'd1, 32'h00ff_ffff, "R11 reload width");
    wr(2'd0, 32'hffff_fff8);
    rd(2'd0, 32'h0, "R2 only low bits writable");
    rd(2'd3, 32'd10000, "R9 calibration again");

    idle(2);
    check(exp_q.size(), 0, "scoreboard drained");
    finish_run();
  end
endmodule